// File: doc/BRIEF.md
# Repeat-Mode DMA Address and Count Engine

This block is the address and transfer-count datapath of a single DMA channel that runs in repeat mode. It keeps a memory-side address, a fixed I/O-side address, a reload value and a live countdown. A direction bit decides which of the two addresses is the source and which is the destination. Each transfer-done strobe that arrives while the channel is enabled steps the memory address by one byte or one word, up or down, and counts the live counter down.

When a block of transfers completes, the counter is reloaded from the reload value. In the same cycle the memory address is pulled back by a signed offset of (step size × block length), so it returns to its start value. A one-cycle block-end pulse marks that transfer. The I/O-side address never moves, and its bits above the programmable field are hardwired to ones.

Software programs the channel through a simple write port while the channel is disabled, then sets the enable bit. Bus arbitration, data movement and interrupt generation live outside this block.

Top module: `dma_repeat_engine`

## Requirements
- R1: After reset the memory address, I/O low field, reload value, live counter and control bits are all zero, so `src_addr` is 0, `dst_addr` is all ones above bit IOW with zeros below, and `block_end` is 0.
- R2: Each accepted transfer moves the memory address by 1 when the size bit (control bit 2) is 0 and by 2 when it is 1. The address goes up when the decrement bit (control bit 3) is 0 and down when it is 1. The arithmetic wraps modulo 2^AW.
- R3: The I/O-side address is the I/O low field (write select 1, low IOW bits) with every bit above it set to one, and transfers never change it.
- R4: With the direction bit (control bit 1) at 0, `src_addr` is the memory address and `dst_addr` is the I/O-side address; with it at 1 the two are swapped.
- R5: Each accepted transfer decrements the live counter (write select 3) by 1. A transfer that arrives while the counter holds 1 instead loads it from the reload value (write select 2), which transfers never change.
- R6: A count of zero in the reload value and the live counter gives a block of 2^CW transfers.
- R7: On the transfer that reloads the counter, the memory address becomes its stepped value minus (±1 by increment/decrement) × step × block length, where a reload value of 0 counts as 2^CW. This returns the address to its value at the start of the block.
- R8: `block_end` is high for exactly the one cycle after the transfer that reloads the counter, and low otherwise.
- R9: Transfer strobes are ignored while the enable bit (control bit 0) is 0: neither address nor counter moves, and `block_end` stays low.
- R10: Writes to the memory address (select 0), I/O low field (select 1), reload value (select 2) and live counter (select 3) take effect only while the channel is disabled. The control register (select 4) accepts writes at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 memory address, 1 I/O low field, 2 reload value, 3 live counter, 4 control |
| wr_data | input | AW | Write data, low bits used for the narrower registers |
| xfer_done | input | 1 | One transfer completed this cycle |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| block_end | output | 1 | One-cycle pulse on the block-completing transfer |

## Verification
The bench builds the engine with AW=12, IOW=8 and CW=4, which shrinks the block length to at most 16 transfers. At that size a sweep can cover every reload value, including the zero-means-sixteen case, for all eight combinations of direction, size and increment/decrement. Each combination runs two full blocks from start addresses placed near both ends of the 12-bit space, so wraparound in both directions and the restore across a wrap are checked. Separate short runs cover a live counter that differs from the reload value, and the effect of strobes and writes while the channel is disabled or enabled.

// File: rtl/dma_repeat_engine.sv
module dma_repeat_engine #(
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          xfer_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          block_end
);
  localparam int HW = AW - IOW;

  logic [AW-1:0]  mem_q;
  logic [IOW-1:0] io_q;
  logic [CW-1:0]  hold_q, live_q;
  logic           en_q, dir_q, word_q, dec_q;

  logic          take, last;
  logic [AW-1:0] step, stepped, offset, io_addr;
  logic [CW:0]   span;

  assign take    = en_q & xfer_done;
  assign last    = (live_q == CW'(1));
  assign step    = word_q ? AW'(2) : AW'(1);
  assign stepped = dec_q ? mem_q - step : mem_q + step;
  assign span    = (hold_q == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, hold_q};
  assign offset  = {{(AW-CW-1){1'b0}}, span} << word_q;
  assign io_addr = {{HW{1'b1}}, io_q};

  assign src_addr = dir_q ? io_addr : mem_q;
  assign dst_addr = dir_q ? mem_q : io_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q     <= '0;
      io_q      <= '0;
      hold_q    <= '0;
      live_q    <= '0;
      en_q      <= 1'b0;
      dir_q     <= 1'b0;
      word_q    <= 1'b0;
      dec_q     <= 1'b0;
      block_end <= 1'b0;
    end else begin
      block_end <= take & last;
      if (take) begin
        if (last) begin
          live_q <= hold_q;
          mem_q  <= dec_q ? stepped + offset : stepped - offset;
        end else begin
          live_q <= live_q - CW'(1);
          mem_q  <= stepped;
        end
      end
      if (wr_en) begin
        if (wr_sel == 3'd4) begin
          en_q   <= wr_data[0];
          dir_q  <= wr_data[1];
          word_q <= wr_data[2];
          dec_q  <= wr_data[3];
        end else if (!en_q) begin
          case (wr_sel)
            3'd0:    mem_q  <= wr_data;
            3'd1:    io_q   <= wr_data[IOW-1:0];
            3'd2:    hold_q <= wr_data[CW-1:0];
            3'd3:    live_q <= wr_data[CW-1:0];
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dma_repeat_engine_props.sv
module dma_repeat_engine_props #(
  parameter int AW  = 24,
  parameter int IOW = 16,
  parameter int CW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [2:0]    wr_sel,
  input logic          xfer_done,
  input logic          en_q,
  input logic          word_q,
  input logic          dec_q,
  input logic [AW-1:0] mem_q,
  input logic [IOW-1:0] io_q,
  input logic [CW-1:0] hold_q,
  input logic [CW-1:0] live_q,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic          block_end
);
  logic take, last;
  assign take = en_q & xfer_done;
  assign last = (live_q == CW'(1));

  assert_up_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && !last && !word_q && !dec_q && !wr_en |=> mem_q == AW'($past(mem_q) + 1'b1));

  assert_down_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take && !last && word_q && dec_q && !wr_en |=> mem_q == AW'($past(mem_q) - 2'd2));

  assert_io_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&src_addr[AW-1:IOW]) || (&dst_addr[AW-1:IOW]));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && !last |=> live_q == CW'($past(live_q) - 1'b1));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take && last |=> live_q == $past(hold_q) && block_end);

  assert_pulse_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && last) |=> !block_end);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !(wr_en && wr_sel == 3'd0) |=> $stable(mem_q));

  assert_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(io_q) && $stable(hold_q));
endmodule

bind dma_repeat_engine dma_repeat_engine_props #(.AW(AW), .IOW(IOW), .CW(CW)) u_props (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .xfer_done(xfer_done),
  .en_q(en_q), .word_q(word_q), .dec_q(dec_q), .mem_q(mem_q), .io_q(io_q),
  .hold_q(hold_q), .live_q(live_q), .src_addr(src_addr), .dst_addr(dst_addr),
  .block_end(block_end)
);

// File: tb/dma_repeat_engine_test.sv
`timescale 1ns/1ps
module dma_repeat_engine_test;
  localparam int AW = 12, IOW = 8, CW = 4;
  localparam int MOD = 1 << AW;
  localparam int IOF = ((1 << (AW - IOW)) - 1) << IOW;

  logic clk = 0, rst_n = 0, wr_en = 0, xfer_done = 0;
  logic [2:0] wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] src_addr, dst_addr;
  logic block_end;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dma_repeat_engine #(.AW(AW), .IOW(IOW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_done(xfer_done), .src_addr(src_addr), .dst_addr(dst_addr), .block_end(block_end)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk); wr_en = 1; wr_sel = 3'(sel); wr_data = AW'(data);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic xfer();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 src after reset", int'(src_addr), 0);
    chk("R1 dst after reset", int'(dst_addr), IOF);
    chk("R1 block_end after reset", int'(block_end), 0);
    rst_n = 1;
    @(negedge clk);
    wr(1, 'hA5);

    for (int dir = 0; dir < 2; dir++)
      for (int word = 0; word < 2; word++)
        for (int dec = 0; dec < 2; dec++)
          for (int hold = 0; hold < (1 << CW); hold++) begin
            int start, n, stp;
            start = dec ? 'h003 : 'hFFA;
            n = (hold == 0) ? (1 << CW) : hold;
            stp = word ? 2 : 1;
            wr(4, 0);
            wr(0, start); wr(2, hold); wr(3, hold);
            wr(4, 1 | (dir << 1) | (word << 2) | (dec << 3));
            for (int blk = 0; blk < 2; blk++)
              for (int k = 1; k <= n; k++) begin
                int expm, mact, iact;
                xfer();
                expm = (k == n) ? start
                     : (dec ? (start - stp * k + MOD * 64) % MOD : (start + stp * k) % MOD);
                mact = dir ? int'(dst_addr) : int'(src_addr);
                iact = dir ? int'(src_addr) : int'(dst_addr);
                if (k == n) chk(hold == 0 ? "R7 R6 restore full block" : "R7 restore", mact, expm);
                else        chk(word ? "R2 word step" : "R2 byte step", mact, expm);
                chk(dir ? "R4 R3 io as source" : "R4 R3 io as dest", iact, IOF | 'hA5);
                chk(hold == 0 ? "R8 R6 block_end" : "R8 R5 block_end", int'(block_end), k == n);
              end
          end

    // live counter differs from reload value: first block short, then reload length
    wr(4, 0); wr(0, 'h100); wr(2, 5); wr(3, 2); wr(4, 1);
    for (int k = 1; k <= 7; k++) begin
      xfer();
      chk("R5 reload from hold", int'(block_end), (k == 2 || k == 7) ? 1 : 0);
    end

    // disabled channel ignores strobes
    wr(4, 0); wr(0, 'h200); wr(2, 1); wr(3, 1);
    xfer();
    chk("R9 addr unchanged when disabled", int'(src_addr), 'h200);
    chk("R9 no block_end when disabled", int'(block_end), 0);
    wr(4, 1);
    xfer();
    chk("R9 first enabled strobe completes block", int'(block_end), 1);
    chk("R9 hold 1 returns address", int'(src_addr), 'h200);

    // writes locked while enabled, control still writable
    wr(0, 'h777);
    chk("R10 mem write ignored when enabled", int'(src_addr), 'h200);
    wr(1, 'h3C);
    chk("R10 io write ignored when enabled", int'(dst_addr), IOF | 'hA5);
    wr(4, 3);
    chk("R10 control writable when enabled", int'(src_addr), IOF | 'hA5);
    chk("R10 R4 swapped dest", int'(dst_addr), 'h200);
    wr(4, 0); wr(0, 'h321);
    chk("R10 mem write taken when disabled", int'(src_addr), 'h321);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule